// File: doc/BRIEF.md
# Priority Interrupt Recognition and Acknowledge Controller

This block watches a three-bit encoded interrupt priority request and decides when a processor core must leave its instruction stream to service it. The request is passed through a two-stage synchronizer and a stability filter. The filtered level is then compared with the core's current interrupt mask. Levels one to six are maskable and level-sensitive. The top level is non-maskable and fires once for each entry into that level.

When a request is pending, the core raises an instruction-boundary strobe. If no higher-priority exception is waiting, the block pulses an exception-entry request and starts an acknowledge bus cycle. That cycle is a processor-space access which carries the level in the address. It ends in one of three ways:
- The device drives its vector number on the data bus.
- The device asks for an automatic vector derived from the level.
- The cycle ends in a bus error, which yields the spurious-interrupt vector.

The resulting vector number is presented with a one-cycle valid strobe, together with the new mask value that the core should adopt.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A request level is accepted only after it has been present on two consecutive synchronizer samples. A level that lasts one clock never makes `irq_pending_o` rise. A level held for two or more clocks makes it visible within three clock edges.
- R2: Levels 1 to 6 are pending exactly while the accepted level is strictly greater than `mask_i`. Level 0 is never pending.
- R3: Level 7 becomes pending on a transition into 7, whatever the value of `mask_i`. Once taken, it is not pending again while the input stays at 7. It re-arms only after the input leaves 7.
- R4: An interrupt is taken only on a clock where `boundary_i` is 1, `hi_exc_i` is 0, a request is pending and no acknowledge cycle is in progress. Taking it raises `exc_req_o` for exactly one cycle, in the same cycle that `bus_req_o` rises.
- R5: During an acknowledge cycle, `bus_fc_o` is 3'b111. `bus_addr_o` is all ones except bits 3..1, which hold the acknowledged level, so bits 19..16 read 4'b1111 and bit 0 is 1. While no cycle runs, `bus_req_o`, `bus_addr_o` and `bus_fc_o` are all zero.
- R6: A normal termination (`bus_ack_i`) ends the cycle. On the next cycle `vec_num_o` holds the `bus_rdata_i` byte and `vec_valid_o` is high for exactly one cycle.
- R7: An autovector termination (`bus_avec_i`) gives a vector number of 24 plus the level, and the data bus is ignored.
- R8: A bus-error termination (`bus_err_i`) gives vector 24 and no mask update.
- R9: After a normal or autovector termination, `mask_upd_valid_o` pulses in the same cycle as `vec_valid_o`, and `mask_upd_o` carries the acknowledged level.
- R10: After reset, every output is zero.
- R11: When several terminations arrive together, bus error takes precedence over autovector, and autovector takes precedence over normal.
- R12: While a cycle waits for termination, its address is held, and further boundary strobes start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level_i | input | 3 | Encoded request level, 0 = none |
| mask_i | input | 3 | Current interrupt mask |
| boundary_i | input | 1 | Instruction-boundary strobe |
| hi_exc_i | input | 1 | A higher-priority exception is pending |
| exc_req_o | output | 1 | One-cycle exception-entry request |
| irq_pending_o | output | 1 | An interrupt is pending |
| bus_req_o | output | 1 | Acknowledge bus cycle active |
| bus_addr_o | output | 32 | Acknowledge cycle address |
| bus_fc_o | output | 3 | Function code of the cycle |
| bus_rdata_i | input | 8 | Vector byte from the device |
| bus_ack_i | input | 1 | Normal termination |
| bus_avec_i | input | 1 | Autovector termination |
| bus_err_i | input | 1 | Bus-error termination |
| vec_valid_o | output | 1 | Vector number valid strobe |
| vec_num_o | output | 8 | Vector number |
| mask_upd_valid_o | output | 1 | Mask update strobe |
| mask_upd_o | output | 3 | New mask value |

## Verification
The level-against-mask comparison is tried with the following patterns:
- Levels above, equal to and below the mask. These separate a strict comparison from a greater-or-equal one.
- Level 7 under the highest mask. This shows that the top level bypasses the mask.
- Level 7 held after it has been serviced, and then released and raised again. This separates edge detection from level detection.

Each termination kind is applied with a data byte whose value differs from the autovector result, so the bench can tell whether the bus was read or ignored. Pulses lasting one clock and two clocks show whether the filter requires two equal samples. Boundary strobes are also given while a higher-priority exception is pending and while a cycle is already running.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int LVL_W  = 3;
    localparam int ADDR_W = 32;
    localparam int VEC_W  = 8;
    localparam int FC_W   = 3;
    localparam int SYNC_STAGES = 2;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam lvl_t LVL_NONE = '0;
    localparam lvl_t LVL_NMI  = '1;
    localparam logic [FC_W-1:0] FC_CPU_SPACE = '1;
    localparam vec_t VEC_AUTO_BASE = 8'd24;
    localparam vec_t VEC_SPURIOUS  = 8'd24;

    typedef enum logic [1:0] {
        TERM_NONE,
        TERM_NORMAL,
        TERM_AUTO,
        TERM_ERR
    } term_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } ack_state_e;

    typedef struct packed {
        logic pending;
        lvl_t level;
    } req_t;

    typedef struct packed {
        logic             active;
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]  fc;
    } bus_cmd_t;

    function automatic logic [ADDR_W-1:0] ack_address(input lvl_t l);
        logic [ADDR_W-1:0] a;
        a = '1;
        a[LVL_W:1] = l;
        return a;
    endfunction

    function automatic vec_t auto_vector(input lvl_t l);
        return VEC_AUTO_BASE + vec_t'(l);
    endfunction

    function automatic term_e resolve_term(input logic ack, input logic avec, input logic err);
        if (err)       return TERM_ERR;
        else if (avec) return TERM_AUTO;
        else if (ack)  return TERM_NORMAL;
        else           return TERM_NONE;
    endfunction

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync
    import irq_ack_pkg::*;
#(
    parameter int W      = LVL_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Accept a new value only when the last two stages agree.
    always_ff @(posedge clk) begin
        if (rst)
            level_q <= '0;
        else if (stage_q[STAGES-1] == stage_q[STAGES-2])
            level_q <= stage_q[STAGES-1];
    end

    assign level_o = level_q;
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_ack_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t level_i,
    input  lvl_t mask_i,
    input  logic take_i,
    output req_t req_o
);
    lvl_t prev_q;
    logic nmi_pend_q;
    logic nmi_edge;
    logic maskable;

    assign nmi_edge = (level_i == LVL_NMI) && (prev_q != LVL_NMI);
    assign maskable = (level_i != LVL_NONE) && (level_i != LVL_NMI) && (level_i > mask_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= LVL_NONE;
            nmi_pend_q <= 1'b0;
        end else begin
            prev_q <= level_i;
            if (nmi_edge)
                nmi_pend_q <= 1'b1;
            else if (take_i && nmi_pend_q)
                nmi_pend_q <= 1'b0;
        end
    end

    always_comb begin
        req_o.pending = nmi_pend_q || maskable;
        req_o.level   = nmi_pend_q ? LVL_NMI : level_i;
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_t     req_i,
    input  logic     boundary_i,
    input  logic     hi_exc_i,
    input  vec_t     rdata_i,
    input  logic     ack_i,
    input  logic     avec_i,
    input  logic     err_i,
    output logic     take_o,
    output logic     exc_req_o,
    output bus_cmd_t cmd_o,
    output logic     vec_valid_o,
    output vec_t     vec_o,
    output logic     mupd_valid_o,
    output lvl_t     mupd_o
);
    ack_state_e state_q;
    lvl_t       lvl_q;
    term_e      term;

    assign term   = resolve_term(ack_i, avec_i, err_i);
    assign take_o = (state_q == ST_IDLE) && req_i.pending && boundary_i && !hi_exc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            lvl_q        <= LVL_NONE;
            exc_req_o    <= 1'b0;
            vec_valid_o  <= 1'b0;
            vec_o        <= '0;
            mupd_valid_o <= 1'b0;
            mupd_o       <= LVL_NONE;
        end else begin
            exc_req_o    <= 1'b0;
            vec_valid_o  <= 1'b0;
            mupd_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_o) begin
                        state_q   <= ST_ACK;
                        lvl_q     <= req_i.level;
                        exc_req_o <= 1'b1;
                    end
                end
                ST_ACK: begin
                    if (term != TERM_NONE) begin
                        state_q     <= ST_IDLE;
                        vec_valid_o <= 1'b1;
                        case (term)
                            TERM_NORMAL: vec_o <= rdata_i;
                            TERM_AUTO:   vec_o <= auto_vector(lvl_q);
                            default:     vec_o <= VEC_SPURIOUS;
                        endcase
                        if (term != TERM_ERR) begin
                            mupd_valid_o <= 1'b1;
                            mupd_o       <= lvl_q;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o.active = (state_q == ST_ACK);
        cmd_o.addr   = cmd_o.active ? ack_address(lvl_q) : '0;
        cmd_o.fc     = cmd_o.active ? FC_CPU_SPACE : '0;
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic [LVL_W-1:0]  mask_i,
    input  logic              boundary_i,
    input  logic              hi_exc_i,
    output logic              exc_req_o,
    output logic              irq_pending_o,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [FC_W-1:0]   bus_fc_o,
    input  logic [VEC_W-1:0]  bus_rdata_i,
    input  logic              bus_ack_i,
    input  logic              bus_avec_i,
    input  logic              bus_err_i,
    output logic              vec_valid_o,
    output logic [VEC_W-1:0]  vec_num_o,
    output logic              mask_upd_valid_o,
    output logic [LVL_W-1:0]  mask_upd_o
);
    lvl_t     level;
    req_t     req;
    logic     take;
    bus_cmd_t cmd;

    irq_level_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (irq_level_i),
        .level_o (level)
    );

    irq_recognizer u_recog (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .mask_i  (mask_i),
        .take_i  (take),
        .req_o   (req)
    );

    irq_ack_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .boundary_i   (boundary_i),
        .hi_exc_i     (hi_exc_i),
        .rdata_i      (bus_rdata_i),
        .ack_i        (bus_ack_i),
        .avec_i       (bus_avec_i),
        .err_i        (bus_err_i),
        .take_o       (take),
        .exc_req_o    (exc_req_o),
        .cmd_o        (cmd),
        .vec_valid_o  (vec_valid_o),
        .vec_o        (vec_num_o),
        .mupd_valid_o (mask_upd_valid_o),
        .mupd_o       (mask_upd_o)
    );

    assign irq_pending_o = req.pending;
    assign bus_req_o     = cmd.active;
    assign bus_addr_o    = cmd.addr;
    assign bus_fc_o      = cmd.fc;
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk
    import irq_ack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              boundary_i,
    input logic              hi_exc_i,
    input logic              exc_req_o,
    input logic              bus_req_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [FC_W-1:0]   bus_fc_o,
    input logic              bus_ack_i,
    input logic              bus_avec_i,
    input logic              bus_err_i,
    input logic              vec_valid_o,
    input logic [VEC_W-1:0]  vec_num_o,
    input logic              mask_upd_valid_o,
    input logic [LVL_W-1:0]  mask_upd_o
);
    assert_cpu_space_R5: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |-> (bus_fc_o == 3'b111) && (bus_addr_o[31:4] == '1) && bus_addr_o[0]);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_req_o |-> (bus_fc_o == '0) && (bus_addr_o == '0));

    assert_take_gate_R4: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> bus_req_o && $past(boundary_i) && !$past(hi_exc_i) && !$past(bus_req_o));

    assert_vec_after_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> $past(bus_req_o) && !bus_req_o);

    assert_vec_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |=> !vec_valid_o);

    assert_mask_update_R9: assert property (@(posedge clk) disable iff (rst)
        mask_upd_valid_o |-> vec_valid_o && (mask_upd_o == $past(bus_addr_o[3:1])));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !(bus_ack_i || bus_avec_i || bus_err_i)) |=> bus_req_o && $stable(bus_addr_o));

    assert_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o && $past(bus_err_i)) |-> !mask_upd_valid_o && (vec_num_o == 8'd24));

    assert_autovec_R7: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o && $past(bus_avec_i) && !$past(bus_err_i))
            |-> (vec_num_o == 8'd24 + {5'd0, $past(bus_addr_o[3:1])}));
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk u_chk (.*);

// File: tb/irq_ack_ctrl_test.sv
module irq_ack_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  irq_level_i = '0;
    logic [2:0]  mask_i = '0;
    logic        boundary_i = 1'b0;
    logic        hi_exc_i = 1'b0;
    logic        exc_req_o;
    logic        irq_pending_o;
    logic        bus_req_o;
    logic [31:0] bus_addr_o;
    logic [2:0]  bus_fc_o;
    logic [7:0]  bus_rdata_i = '0;
    logic        bus_ack_i = 1'b0;
    logic        bus_avec_i = 1'b0;
    logic        bus_err_i = 1'b0;
    logic        vec_valid_o;
    logic [7:0]  vec_num_o;
    logic        mask_upd_valid_o;
    logic [2:0]  mask_upd_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    irq_ack_ctrl uut (.*);

    // {level, mask, term(0 none,1 normal,2 auto,3 error), data, pending, vector}
    localparam int NV = 10;
    localparam logic [24:0] VECTORS [NV] = '{
        {3'd3, 3'd1, 2'd1, 8'h40, 1'b1, 8'h40},
        {3'd3, 3'd3, 2'd0, 8'h00, 1'b0, 8'h00},
        {3'd2, 3'd5, 2'd0, 8'h00, 1'b0, 8'h00},
        {3'd6, 3'd5, 2'd2, 8'hAA, 1'b1, 8'd30},
        {3'd5, 3'd0, 2'd3, 8'h11, 1'b1, 8'd24},
        {3'd7, 3'd7, 2'd1, 8'h9C, 1'b1, 8'h9C},
        {3'd7, 3'd0, 2'd2, 8'h55, 1'b1, 8'd31},
        {3'd0, 3'd0, 2'd0, 8'h00, 1'b0, 8'h00},
        {3'd1, 3'd0, 2'd1, 8'h01, 1'b1, 8'h01},
        {3'd4, 3'd6, 2'd0, 8'h00, 1'b0, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_term(input int term);
        bus_ack_i  = (term == 1);
        bus_avec_i = (term == 2);
        bus_err_i  = (term == 3);
    endtask

    task automatic do_take(input logic [2:0] lv, input int term,
                           input logic [7:0] data, input logic [7:0] exp_vec);
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        chk("R4 exc_req pulse", exc_req_o, 1);
        chk("R5 ack address", bus_addr_o, {28'hFFFFFFF, lv, 1'b1});
        chk("R5 function code", bus_fc_o, 3'b111);
        bus_rdata_i = data;
        set_term(term);
        @(negedge clk);
        set_term(0);
        bus_rdata_i = 8'h00;
        chk("R6 vec_valid", vec_valid_o, 1);
        chk("R6/R7/R8 vector", vec_num_o, exp_vec);
        chk("R9 mask update strobe", mask_upd_valid_o, term != 3);
        if (term != 3) chk("R9 mask value", mask_upd_o, lv);
        chk("R4 exc_req one cycle", exc_req_o, 0);
        @(negedge clk);
        chk("R6 vec_valid one cycle", vec_valid_o, 0);
        chk("R5 bus idle", {bus_req_o, bus_fc_o, bus_addr_o}, 0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(4);
        // R10: reset state
        chk("R10 outputs after reset",
            {exc_req_o, irq_pending_o, bus_req_o, bus_addr_o, bus_fc_o,
             vec_valid_o, vec_num_o, mask_upd_valid_o, mask_upd_o}, 0);
        rst = 1'b0;
        wait_cyc(2);
        chk("R10 outputs after release", {bus_req_o, vec_valid_o, irq_pending_o}, 0);

        // Table walk: R2, R3, R5..R9
        for (int i = 0; i < NV; i++) begin
            logic [2:0] lv;
            logic [2:0] mk;
            int         tm;
            logic [7:0] dt;
            logic       pend;
            logic [7:0] vec;
            {lv, mk, tm, dt, pend, vec} = {VECTORS[i][24:22], VECTORS[i][21:19],
                                           30'd0, VECTORS[i][18:17], VECTORS[i][16:9],
                                           VECTORS[i][8], VECTORS[i][7:0]};
            mask_i = mk;
            irq_level_i = lv;
            wait_cyc(5);
            chk("R2 pending vs mask", irq_pending_o, pend);
            if (pend) begin
                do_take(lv, tm, dt, vec);
                if (lv == 3'd7) begin
                    wait_cyc(3);
                    chk("R3 held level 7 not pending again", irq_pending_o, 0);
                end
            end else begin
                boundary_i = 1'b1;
                @(negedge clk);
                boundary_i = 1'b0;
                chk("R4 no cycle without pending", bus_req_o, 0);
            end
            irq_level_i = 3'd0;
            wait_cyc(5);
        end

        // R3: re-arm after leaving 7
        mask_i = 3'd7;
        irq_level_i = 3'd7;
        wait_cyc(5);
        do_take(3'd7, 2, 8'h00, 8'd31);
        wait_cyc(3);
        chk("R3 stays quiet at 7", irq_pending_o, 0);
        irq_level_i = 3'd0;
        wait_cyc(5);
        irq_level_i = 3'd7;
        wait_cyc(5);
        chk("R3 re-armed after leaving 7", irq_pending_o, 1);
        do_take(3'd7, 1, 8'h77, 8'h77);
        irq_level_i = 3'd0;
        mask_i = 3'd0;
        wait_cyc(5);

        // R1: one-cycle glitch is filtered
        begin
            logic seen;
            seen = 1'b0;
            irq_level_i = 3'd5;
            @(negedge clk);
            irq_level_i = 3'd0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                seen |= irq_pending_o;
            end
            chk("R1 one-cycle glitch ignored", seen, 0);
            seen = 1'b0;
            irq_level_i = 3'd5;
            wait_cyc(2);
            irq_level_i = 3'd0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                seen |= irq_pending_o;
            end
            chk("R1 two-cycle level accepted", seen, 1);
        end
        wait_cyc(3);

        // R4: higher-priority exception blocks the take
        irq_level_i = 3'd4;
        wait_cyc(5);
        hi_exc_i = 1'b1;
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        hi_exc_i = 1'b0;
        chk("R4 blocked by higher exception", {exc_req_o, bus_req_o}, 0);
        wait_cyc(2);
        chk("R4 no start without boundary", bus_req_o, 0);

        // R12: boundary during a running cycle; R11: error beats autovector
        boundary_i = 1'b1;
        @(negedge clk);
        chk("R4 take", bus_req_o, 1);
        @(negedge clk);
        boundary_i = 1'b0;
        chk("R12 no second start", exc_req_o, 0);
        chk("R12 address held", bus_addr_o, {28'hFFFFFFF, 3'd4, 1'b1});
        wait_cyc(2);
        chk("R12 still waiting", bus_req_o, 1);
        bus_rdata_i = 8'hEE;
        bus_avec_i = 1'b1;
        bus_err_i = 1'b1;
        bus_ack_i = 1'b1;
        @(negedge clk);
        set_term(0);
        chk("R11 error wins vector", vec_num_o, 8'd24);
        chk("R11 error wins no mask update", mask_upd_valid_o, 0);
        @(negedge clk);

        // R11: autovector beats normal
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        bus_ack_i = 1'b1;
        bus_avec_i = 1'b1;
        @(negedge clk);
        set_term(0);
        chk("R11 autovector beats normal", vec_num_o, 8'd28);
        chk("R9 mask update level 4", {mask_upd_valid_o, mask_upd_o}, {1'b1, 3'd4});
        irq_level_i = 3'd0;
        wait_cyc(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule